// File: doc/BRIEF.md
# Security Monitor State Machine

This block decides whether the memory controller next to it may run, and whether that controller uses the secret key or the default key. After reset the monitor passes through a fixed-length RAM zeroize phase and lands in a health-check state. Software then proves it is alive by writing a three-step sequence to the sequence-checker registers. A correct sequence makes the monitor secure. A wrong value or a wrong order makes it non-secure. Any alarm, from software or from the alarm pin, locks the monitor into a fail state that only reset leaves.

Software reaches the block through a plain single-cycle write strobe with a two-bit register address. A write is taken on the clock edge at which `wr_en` is high. There is no back-pressure: every write is accepted in its cycle. The five-bit state code, the key select, the blocked line and the interrupt lines are plain level outputs. Each of them changes on the clock edge that takes the write or alarm which causes the change.

Top module: `smn_monitor`

## Requirements
- R1: While reset is held, `state_code` is 0x00 (start), `mem_blocked` is 1, and `irq`, `irq_pending`, `secret_key_sel` and `tamper_locked` are 0.
- R2: One clock after reset release the code becomes 0x05 (zeroize). It holds for exactly ZERO_CYCLES clocks and then becomes 0x06 (health check).
- R3: In health check, three writes in order move the code to 0x0A (secure): 0xAAAA to address 1 (sequence start), 0x5555 to address 2 (sequence end), then 0x5555 to address 3 (sequence check). `secret_key_sel` is 1 only while the code is 0x0A.
- R4: In health check, each of the following moves the code to 0x0C (non-secure): a sequence write out of the order 1,2,3; a check value that differs from the end value; or a start or end value other than 0xAAAA or 0x5555.
- R5: Writes to addresses 1 to 3 in any state other than health check leave the state unchanged.
- R6: A write to address 0 (command) with bit 0 (software alarm) set moves health check, secure or non-secure to 0x09 (fail). The same write in start or zeroize has no effect on the state.
- R7: Fail (0x09) is kept until reset, whatever is written and whatever the alarm pin does.
- R8: A high `alarm_in` acts like the software alarm: it moves health check, secure or non-secure to fail, and it is ignored in start and zeroize.
- R9: `mem_blocked` is 0 in secure and non-secure and 1 in every other state.
- R10: Every change of state code sets `irq_pending`. A command write loads the interrupt enable from bit 1. `irq` is `irq_pending` AND that enable.
- R11: Command bit 3 clears `irq_pending`. If a state change happens on the same edge, the pending flag stays set.
- R12: Command bit 4 sets `tamper_locked`, which stays 1 until reset. Command bit 2 (clear bit bank) changes no state, key, blocked or interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | 0 command, 1 sequence start, 2 sequence end, 3 sequence check |
| wr_data | input | DATA_W | Write data |
| alarm_in | input | 1 | Hardware alarm, level sensitive |
| state_code | output | 5 | Current state code |
| secret_key_sel | output | 1 | 1 selects the secret key, 0 the default key |
| mem_blocked | output | 1 | Memory controller blocked |
| irq_pending | output | 1 | State change not yet acknowledged |
| irq | output | 1 | Interrupt request |
| tamper_locked | output | 1 | Sticky tamper lock flag |

## Verification
The sequence checker is driven with the one correct three-write order. Runs of random addresses and values, drawn mostly from the two key values, separate a value mismatch from an order error and from a good sequence that happens to be built from random draws. Alarms are sent in every state: in start and zeroize they must have no effect, and in the other states they must lead to a terminal fail. Directed edges then pin down the exact zeroize length and the case where an interrupt clear and a state change fall on the same edge.

// File: rtl/smn_pkg.sv
package smn_pkg;

  typedef enum logic [4:0] {
    ST_START   = 5'h00,
    ST_ZERO    = 5'h05,
    ST_HEALTH  = 5'h06,
    ST_FAIL    = 5'h09,
    ST_SECURE  = 5'h0A,
    ST_NONSEC  = 5'h0C
  } smn_state_e;

  typedef logic [1:0] smn_addr_t;

  localparam smn_addr_t A_CMD        = 2'd0;
  localparam smn_addr_t A_SEQ_BEGIN  = 2'd1;
  localparam smn_addr_t A_SEQ_FINAL  = 2'd2;
  localparam smn_addr_t A_SEQ_VERIFY = 2'd3;

  localparam int B_ALARM    = 0;
  localparam int B_IRQ_EN   = 1;
  localparam int B_BANK_CLR = 2;
  localparam int B_IRQ_CLR  = 3;
  localparam int B_TAMPER   = 4;

  localparam int CMD_BITS = 5;

endpackage

// File: rtl/smn_zero_timer.sv
module smn_zero_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (!done)    cnt_q <= cnt_q + 1'b1;
  end

  AST_ZERO_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST) else $error("zeroize counter overran"); // R2

endmodule

// File: rtl/smn_seq_check.sv
module smn_seq_check
  import smn_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter logic [DATA_W-1:0] START_KEY = 'hAAAA,
  parameter logic [DATA_W-1:0] END_KEY   = 'h5555
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              wr_en,
  input  smn_addr_t         wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              verdict_valid,
  output logic              verdict_pass
);
  typedef enum logic [1:0] {STEP_IDLE, STEP_HAVE_BEGIN, STEP_HAVE_FINAL} step_e;

  step_e             step_q;
  logic [DATA_W-1:0] begin_q;
  logic [DATA_W-1:0] final_q;
  logic              seq_wr;

  assign seq_wr = armed && wr_en && (wr_addr != A_CMD);

  always_comb begin
    verdict_valid = 1'b0;
    verdict_pass  = 1'b0;
    if (seq_wr) begin
      unique case (wr_addr)
        A_SEQ_BEGIN:  verdict_valid = (step_q != STEP_IDLE);
        A_SEQ_FINAL:  verdict_valid = (step_q != STEP_HAVE_BEGIN);
        A_SEQ_VERIFY: begin
          verdict_valid = 1'b1;
          verdict_pass  = (step_q == STEP_HAVE_FINAL) && (wr_data == final_q)
                          && (begin_q == START_KEY) && (final_q == END_KEY);
        end
        default: verdict_valid = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= STEP_IDLE;
      begin_q <= '0;
      final_q <= '0;
    end else if (!armed) begin
      step_q  <= STEP_IDLE;
    end else if (seq_wr && !verdict_valid) begin
      if (wr_addr == A_SEQ_BEGIN) begin
        begin_q <= wr_data;
        step_q  <= STEP_HAVE_BEGIN;
      end else if (wr_addr == A_SEQ_FINAL) begin
        final_q <= wr_data;
        step_q  <= STEP_HAVE_FINAL;
      end
    end
  end

  AST_VERDICT_ENDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !armed) else $error("verdict did not leave health"); // R4

endmodule

// File: rtl/smn_irq_ctrl.sv
module smn_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic state_change,
  input  logic cmd_wr,
  input  logic cmd_en_bit,
  input  logic cmd_clr_bit,
  output logic pending,
  output logic irq
);
  logic pending_q;
  logic enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      enable_q  <= 1'b0;
    end else begin
      if (state_change)                  pending_q <= 1'b1;
      else if (cmd_wr && cmd_clr_bit)    pending_q <= 1'b0;
      if (cmd_wr)                        enable_q  <= cmd_en_bit;
    end
  end

  assign pending = pending_q;
  assign irq     = pending_q & enable_q;

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    state_change |=> pending) else $error("state change lost"); // R11

endmodule

// File: rtl/smn_monitor.sv
module smn_monitor
  import smn_pkg::*;
#(
  parameter int                ZERO_CYCLES = 16,
  parameter int                DATA_W      = 16,
  parameter logic [DATA_W-1:0] START_KEY   = 'hAAAA,
  parameter logic [DATA_W-1:0] END_KEY     = 'h5555
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alarm_in,
  output logic [4:0]        state_code,
  output logic              secret_key_sel,
  output logic              mem_blocked,
  output logic              irq_pending,
  output logic              irq,
  output logic              tamper_locked
);
  smn_state_e state_q, state_d;
  logic       cmd_wr;
  logic       any_alarm;
  logic       zero_done;
  logic       verdict_valid, verdict_pass;
  logic       state_change;
  logic       tamper_q;

  assign cmd_wr    = wr_en && (wr_addr == A_CMD);
  assign any_alarm = alarm_in || (cmd_wr && wr_data[B_ALARM]);

  smn_zero_timer #(.CYCLES(ZERO_CYCLES)) u_zero (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_ZERO),
    .done  (zero_done)
  );

  smn_seq_check #(
    .DATA_W    (DATA_W),
    .START_KEY (START_KEY),
    .END_KEY   (END_KEY)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .armed         (state_q == ST_HEALTH),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .verdict_valid (verdict_valid),
    .verdict_pass  (verdict_pass)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_START:  state_d = ST_ZERO;
      ST_ZERO:   if (zero_done) state_d = ST_HEALTH;
      ST_HEALTH: begin
        if (any_alarm)          state_d = ST_FAIL;
        else if (verdict_valid) state_d = verdict_pass ? ST_SECURE : ST_NONSEC;
      end
      ST_SECURE, ST_NONSEC: if (any_alarm) state_d = ST_FAIL;
      ST_FAIL:   state_d = ST_FAIL;
      default:   state_d = ST_FAIL;
    endcase
  end

  assign state_change = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_START;
      tamper_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cmd_wr && wr_data[B_TAMPER]) tamper_q <= 1'b1;
    end
  end

  smn_irq_ctrl u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_change (state_change),
    .cmd_wr       (cmd_wr),
    .cmd_en_bit   (wr_data[B_IRQ_EN]),
    .cmd_clr_bit  (wr_data[B_IRQ_CLR]),
    .pending      (irq_pending),
    .irq          (irq)
  );

  assign state_code     = state_q;
  assign secret_key_sel = (state_q == ST_SECURE);
  assign mem_blocked    = !((state_q == ST_SECURE) || (state_q == ST_NONSEC));
  assign tamper_locked  = tamper_q;

  AST_FAIL_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FAIL |=> state_q == ST_FAIL) else $error("left fail"); // R7

  AST_SECURE_ONLY_FROM_HEALTH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SECURE && $past(state_q) != ST_SECURE) |-> $past(state_q) == ST_HEALTH)
    else $error("secure entered from wrong state"); // R3

  AST_HEALTH_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HEALTH && $past(state_q) != ST_HEALTH) |-> $past(state_q) == ST_ZERO)
    else $error("health entered without zeroize"); // R2

  AST_CHANGE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != $past(state_q)) |-> irq_pending) else $error("pending not set"); // R10

  AST_KEY_NEEDS_UNBLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !(secret_key_sel && mem_blocked)) else $error("key used while blocked"); // R9

  AST_TAMPER_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tamper_locked |=> tamper_locked) else $error("tamper lock dropped"); // R12

endmodule

// File: tb/smn_monitor_test.sv
module smn_monitor_test;
  localparam int ZC = 16;
  localparam logic [4:0] C_START = 5'h00, C_ZERO = 5'h05, C_HEALTH = 5'h06,
                         C_FAIL = 5'h09, C_SEC = 5'h0A, C_NON = 5'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        alarm_in = 1'b0;
  logic [4:0]  state_code;
  logic        secret_key_sel, mem_blocked, irq_pending, irq, tamper_locked;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // model of the sequence checker built from the requirements
  logic [4:0]  m_state;
  int          m_step;
  logic [15:0] m_begin, m_final;

  always #10 clk = ~clk;

  smn_monitor #(.ZERO_CYCLES(ZC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alarm_in(alarm_in), .state_code(state_code), .secret_key_sel(secret_key_sel),
    .mem_blocked(mem_blocked), .irq_pending(irq_pending), .irq(irq),
    .tamper_locked(tamper_locked)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_blocked(input logic [4:0] s);
    return !(s == C_SEC || s == C_NON);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic boot();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; alarm_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (ZC + 1) @(negedge clk);
    m_state = C_HEALTH; m_step = 0; m_begin = '0; m_final = '0;
  endtask

  task automatic model_wr(input logic [1:0] a, input logic [15:0] d);
    if (a == 2'd0) begin
      if (d[0] && (m_state == C_HEALTH || m_state == C_SEC || m_state == C_NON)) m_state = C_FAIL;
    end else if (m_state == C_HEALTH) begin
      if (a == 2'd1) begin
        if (m_step == 0) begin m_begin = d; m_step = 1; end else m_state = C_NON;
      end else if (a == 2'd2) begin
        if (m_step == 1) begin m_final = d; m_step = 2; end else m_state = C_NON;
      end else begin
        if (m_step == 2 && d == m_final && m_begin == 16'hAAAA && m_final == 16'h5555)
          m_state = C_SEC;
        else m_state = C_NON;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 code", state_code, C_START);
    chk("R1 blocked", mem_blocked, 1);
    chk("R1 irq", {irq, irq_pending, secret_key_sel, tamper_locked}, 0);

    // R2 zeroize length
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 zero entry", state_code, C_ZERO);
    repeat (ZC - 1) @(negedge clk);
    chk("R2 zero last", state_code, C_ZERO);
    @(negedge clk);
    chk("R2 health", state_code, C_HEALTH);
    chk("R9 blocked health", mem_blocked, 1);
    chk("R10 pending after boot", irq_pending, 1);
    chk("R10 irq disabled", irq, 0);

    // R12 bank clear no effect, R11 clear, R10 enable
    wr(2'd0, 16'h0004);
    chk("R12 bank clear state", state_code, C_HEALTH);
    chk("R12 bank clear pending", irq_pending, 1);
    wr(2'd0, 16'h000A);
    chk("R11 cleared", irq_pending, 0);
    chk("R10 enabled no pending", irq, 0);
    wr(2'd0, 16'h0012);
    chk("R12 tamper set", tamper_locked, 1);
    chk("R12 tamper state", state_code, C_HEALTH);

    // R3 good sequence
    wr(2'd1, 16'hAAAA);
    wr(2'd2, 16'h5555);
    chk("R3 not yet", state_code, C_HEALTH);
    wr(2'd3, 16'h5555);
    chk("R3 secure", state_code, C_SEC);
    chk("R3 key", secret_key_sel, 1);
    chk("R9 unblocked", mem_blocked, 0);
    chk("R10 irq", {irq_pending, irq}, 2'b11);
    chk("R12 tamper sticky", tamper_locked, 1);
    // R5 writes ignored in secure
    wr(2'd1, 16'h1234);
    wr(2'd3, 16'h0000);
    chk("R5 secure kept", state_code, C_SEC);
    // R11 clear and change on same edge
    wr(2'd0, 16'h000B);
    chk("R6 alarm in secure", state_code, C_FAIL);
    chk("R11 set wins", irq_pending, 1);
    chk("R9 blocked fail", mem_blocked, 1);
    // R7 terminal
    wr(2'd0, 16'h0008);
    wr(2'd1, 16'hAAAA); wr(2'd2, 16'h5555); wr(2'd3, 16'h5555);
    alarm_in = 1'b1; @(negedge clk); alarm_in = 1'b0;
    chk("R7 fail kept", state_code, C_FAIL);
    chk("R7 no new pending", irq_pending, 0);

    // R4 mismatch and order
    boot();
    wr(2'd1, 16'hAAAA); wr(2'd2, 16'h5555); wr(2'd3, 16'h5554);
    chk("R4 mismatch", state_code, C_NON);
    chk("R4 key default", secret_key_sel, 0);
    chk("R9 unblocked non", mem_blocked, 0);
    wr(2'd1, 16'hAAAA); wr(2'd2, 16'h5555); wr(2'd3, 16'h5555);
    chk("R5 nonsecure kept", state_code, C_NON);
    alarm_in = 1'b1; @(negedge clk); alarm_in = 1'b0;
    chk("R8 alarm pin non", state_code, C_FAIL);
    boot();
    wr(2'd2, 16'h5555);
    chk("R4 order", state_code, C_NON);
    boot();
    wr(2'd1, 16'h1111); wr(2'd2, 16'h5555); wr(2'd3, 16'h5555);
    chk("R4 bad begin", state_code, C_NON);
    boot();
    alarm_in = 1'b1; @(negedge clk); alarm_in = 1'b0;
    chk("R8 alarm pin health", state_code, C_FAIL);
    boot();
    wr(2'd0, 16'h0001);
    chk("R6 alarm health", state_code, C_FAIL);

    // R6 R8 alarms ignored during zeroize
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    wr(2'd0, 16'h0001);
    alarm_in = 1'b1; @(negedge clk); alarm_in = 1'b0;
    chk("R6 zero ignores", state_code, C_ZERO);
    repeat (ZC + 2) @(negedge clk);
    chk("R8 zero ignores", state_code, C_HEALTH);

    // random runs against the model: R3 R4 R5 R6
    for (int t = 0; t < 60; t++) begin
      boot();
      for (int k = 0; k < 4; k++) begin
        logic [1:0]  a;
        logic [15:0] d;
        int          pick;
        a = 2'(1 + ($urandom % 3));
        if (($urandom % 10) == 0) a = 2'd0;
        pick = $urandom % 5;
        d = (pick < 2) ? 16'hAAAA : (pick < 4) ? 16'h5555 : 16'($urandom);
        if (a == 2'd0) d = 16'(($urandom % 2) | 16'h0008);
        wr(a, d);
        model_wr(a, d);
        chk("R4 random state", state_code, m_state);
        chk("R9 random blocked", mem_blocked, exp_blocked(m_state));
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule